// File: doc/BRIEF.md
# Power-Management Configuration and I/O Window Decoder

This block holds the configuration-side state of a power-management function. A 32-bit configuration port carries a dword address and a 4-bit byte enable. Through it, software programs two I/O base registers and their enable bits. One base opens a 128-byte power-management window and the other opens a 16-byte SMBus window. Every write that reaches a base register forces that register back into a legal shape. The block then compares incoming 16-bit I/O addresses against each window and raises a hit signal on a match.

The block also forms a level system control interrupt (SCI) from ACPI-style PM1 event status and enable vectors. Only four event classes count: timer (bit 0), global lock (bit 5), power button (bit 8) and RTC alarm (bit 10). The interrupt can reach the output only while the interrupt-pin configuration byte is nonzero. A separate timer-arm output tells the external timer when an overflow event may be raised.

After reset, a small state machine runs two initialisation steps before the block accepts writes:
- **INIT_CLEAR** clears the extended configuration registers.
- **INIT_BASES** loads both base registers with 1.
- **ACTIVE** then accepts writes and stays there until the next reset.

The transitions are unconditional, one per clock edge: INIT_CLEAR to INIT_BASES, INIT_BASES to ACTIVE, and ACTIVE back to itself.

Top module: `pm_cfg_decoder`

## Requirements
- R1: After reset the block spends one cycle in INIT_CLEAR and one in INIT_BASES, then raises `init_done`. Both base registers then read 32'h0000_0001, the window-enable bytes read 0, and both hit outputs are low. A configuration write issued during INIT_CLEAR or INIT_BASES is ignored.
- R2: The power-management base is the dword at byte offset 0x48. After any write that enables at least one of its lanes, the byte lanes are merged and the register holds (merged AND 0x0000FF80) OR 1.
- R3: The SMBus base is the dword at byte offset 0x90. After any write that enables at least one of its lanes, the byte lanes are merged and the register holds (merged AND 0x0000FFF0) OR 1.
- R4: Each byte enable bit k selects byte offset 4*dword+k. A lane whose enable is clear keeps its old value. A single enabled lane is enough to trigger the sanitising of R2 or R3.
- R5: `pm_hit` is high exactly when bit 7 of byte 0x41 is set and the I/O address lies in the 128 bytes starting at bits 15:7 of the power-management base.
- R6: Byte 0xD2 keeps only the low four bits of a write. `smb_hit` is high exactly when bit 0 of byte 0xD2 is set and the I/O address lies in the 16 bytes starting at bits 15:4 of the SMBus base.
- R7: The SCI level is high exactly when, for at least one of event bits 0, 5, 8 and 10, both the status bit and the enable bit are set. All other event bits have no effect.
- R8: The interrupt-pin byte is at offset 0x3D and resets to 1. It is not cleared by INIT_CLEAR. While it is zero, `sci` stays low.
- R9: `tmr_arm` is high exactly when timer enable (bit 0) is set and timer status (bit 0) is clear.
- R10: A write to any dword that holds none of the modelled bytes changes neither base register, enable byte, interrupt-pin byte nor hit output. Reads of such dwords return 0.
- R11: A read strobe captures the addressed dword onto `cfg_rdata` at the next clock edge, and `cfg_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dwaddr | input | 6 | Configuration dword address (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| init_done | output | 1 | High once the block is in ACTIVE |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window |
| evt_sts | input | 16 | PM1 event status bits |
| evt_en | input | 16 | PM1 event enable bits |
| sci | output | 1 | Level system control interrupt |
| tmr_arm | output | 1 | Timer overflow event may be armed |

## Verification
The hardest case to reach from the ports is a partial-lane write into a base register, where the written byte is itself wiped by the sanitising. For example, a write to lane 2 of the power-management base alone must leave the register unchanged. The stimulus reaches it by first programming a known base with a full write and then issuing single-lane writes on lanes 2 and 0, comparing read-back against the merged and masked value. A write placed in the first cycle after reset release, while the machine is still in INIT_CLEAR, checks that writes during initialisation are dropped.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;

    typedef enum logic [1:0] {
        INIT_CLEAR = 2'd0,
        INIT_BASES = 2'd1,
        ACTIVE     = 2'd2
    } init_state_e;

    localparam int DW_AW = 6;

    // dword addresses of the modelled bytes
    localparam logic [DW_AW-1:0] DW_INTPIN = 6'h0F;  // byte 0x3D, lane 1
    localparam logic [DW_AW-1:0] DW_PMCTL  = 6'h10;  // byte 0x41, lane 1
    localparam logic [DW_AW-1:0] DW_PMBASE = 6'h12;  // bytes 0x48..0x4B
    localparam logic [DW_AW-1:0] DW_SMBASE = 6'h24;  // bytes 0x90..0x93
    localparam logic [DW_AW-1:0] DW_SMCTL  = 6'h34;  // byte 0xD2, lane 2

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int k = 0; k < 4; k++)
            r[8*k +: 8] = be[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
        return r;
    endfunction

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_cfg_pkg::*;
#(
    parameter int          IO_AW       = 16,
    parameter int          PM_WIN_BITS = 7,
    parameter int          SM_WIN_BITS = 4,
    parameter logic [7:0]  INTPIN_RST  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [DW_AW-1:0]  cfg_dwaddr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              init_done,
    output logic [31:0]       pm_base,
    output logic [31:0]       sm_base,
    output logic [7:0]        pm_ctl,
    output logic [7:0]        sm_ctl,
    output logic [7:0]        intpin
);
    localparam logic [31:0] IO_SPAN = (32'd1 << IO_AW) - 32'd1;
    localparam logic [31:0] PM_MASK = IO_SPAN & ~((32'd1 << PM_WIN_BITS) - 32'd1);
    localparam logic [31:0] SM_MASK = IO_SPAN & ~((32'd1 << SM_WIN_BITS) - 32'd1);

    init_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INIT_CLEAR;
        else        state_q <= state_d;
    end

    logic do_clear, do_bases, wr_ok;
    always_comb begin
        state_d  = state_q;
        do_clear = 1'b0;
        do_bases = 1'b0;
        wr_ok    = 1'b0;
        unique case (state_q)
            INIT_CLEAR: begin do_clear = 1'b1; state_d = INIT_BASES; end
            INIT_BASES: begin do_bases = 1'b1; state_d = ACTIVE;     end
            ACTIVE:     begin wr_ok    = cfg_wr;                     end
            default:    begin state_d  = INIT_CLEAR;                 end
        endcase
    end
    assign init_done = (state_q == ACTIVE);

    logic        hit_pmb, hit_smb, hit_pmc, hit_smc, hit_pin;
    logic [31:0] pmb_merged, smb_merged;
    always_comb begin
        hit_pmb    = wr_ok && cfg_dwaddr == DW_PMBASE && |cfg_be;
        hit_smb    = wr_ok && cfg_dwaddr == DW_SMBASE && |cfg_be;
        hit_pmc    = wr_ok && cfg_dwaddr == DW_PMCTL  && cfg_be[1];
        hit_smc    = wr_ok && cfg_dwaddr == DW_SMCTL  && cfg_be[2];
        hit_pin    = wr_ok && cfg_dwaddr == DW_INTPIN && cfg_be[1];
        pmb_merged = lane_merge(pm_base, cfg_wdata, cfg_be);
        smb_merged = lane_merge(sm_base, cfg_wdata, cfg_be);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_base <= '0;
            sm_base <= '0;
            pm_ctl  <= '0;
            sm_ctl  <= '0;
            intpin  <= INTPIN_RST;
        end else if (do_clear) begin
            pm_base <= '0;
            sm_base <= '0;
            pm_ctl  <= '0;
            sm_ctl  <= '0;
        end else if (do_bases) begin
            pm_base <= 32'd1;
            sm_base <= 32'd1;
        end else begin
            if (hit_pmb) pm_base <= (pmb_merged & PM_MASK) | 32'd1;
            if (hit_smb) sm_base <= (smb_merged & SM_MASK) | 32'd1;
            if (hit_pmc) pm_ctl  <= cfg_wdata[15:8];
            if (hit_smc) sm_ctl  <= {4'h0, cfg_wdata[19:16]};
            if (hit_pin) intpin  <= cfg_wdata[15:8];
        end
    end

    logic [31:0] rd_word;
    always_comb begin
        unique case (cfg_dwaddr)
            DW_INTPIN: rd_word = {16'h0, intpin, 8'h0};
            DW_PMCTL:  rd_word = {16'h0, pm_ctl, 8'h0};
            DW_PMBASE: rd_word = pm_base;
            DW_SMBASE: rd_word = sm_base;
            DW_SMCTL:  rd_word = {8'h0, sm_ctl, 16'h0};
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_rdata <= '0;
        else if (cfg_rd) cfg_rdata <= rd_word;
    end
endmodule

// File: rtl/pm_io_window.sv
module pm_io_window #(
    parameter int IO_AW    = 16,
    parameter int WIN_BITS = 7
) (
    input  logic [31:0]      base,
    input  logic             enable,
    input  logic [IO_AW-1:0] addr,
    output logic             hit
);
    logic [IO_AW-1:0] base_lo;
    assign base_lo = base[IO_AW-1:0];
    assign hit = enable && (addr[IO_AW-1:WIN_BITS] == base_lo[IO_AW-1:WIN_BITS]);
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen #(
    parameter int           EVT_W    = 16,
    parameter int           TMR_BIT  = 0,
    parameter logic [15:0]  SCI_MASK = 16'h0521
) (
    input  logic [EVT_W-1:0] sts,
    input  logic [EVT_W-1:0] en,
    input  logic [7:0]       intpin,
    output logic             sci,
    output logic             tmr_arm
);
    localparam logic [EVT_W-1:0] MASK = EVT_W'(SCI_MASK);
    logic level;
    assign level   = |(sts & en & MASK);
    assign sci     = level && (intpin != 8'h00);
    assign tmr_arm = en[TMR_BIT] && !sts[TMR_BIT];
endmodule

// File: rtl/pm_cfg_decoder.sv
module pm_cfg_decoder
    import pm_cfg_pkg::*;
#(
    parameter int          IO_AW       = 16,
    parameter int          PM_WIN_BITS = 7,
    parameter int          SM_WIN_BITS = 4,
    parameter int          EVT_W       = 16,
    parameter logic [7:0]  INTPIN_RST  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [5:0]        cfg_dwaddr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              init_done,
    input  logic [IO_AW-1:0]  io_addr,
    output logic              pm_hit,
    output logic              smb_hit,
    input  logic [EVT_W-1:0]  evt_sts,
    input  logic [EVT_W-1:0]  evt_en,
    output logic              sci,
    output logic              tmr_arm
);
    logic [31:0] pm_base, sm_base;
    logic [7:0]  pm_ctl, sm_ctl, intpin;

    pm_cfg_regs #(
        .IO_AW(IO_AW), .PM_WIN_BITS(PM_WIN_BITS),
        .SM_WIN_BITS(SM_WIN_BITS), .INTPIN_RST(INTPIN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_dwaddr(cfg_dwaddr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .init_done(init_done),
        .pm_base(pm_base), .sm_base(sm_base),
        .pm_ctl(pm_ctl), .sm_ctl(sm_ctl), .intpin(intpin)
    );

    localparam int NWIN = 2;
    logic [31:0]    win_base [NWIN];
    logic [NWIN-1:0] win_en, win_hit;
    assign win_base[0] = pm_base;
    assign win_base[1] = sm_base;
    assign win_en      = {sm_ctl[0], pm_ctl[7]};

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int WB = (g == 0) ? PM_WIN_BITS : SM_WIN_BITS;
        pm_io_window #(.IO_AW(IO_AW), .WIN_BITS(WB)) u_win (
            .base(win_base[g]), .enable(win_en[g]),
            .addr(io_addr), .hit(win_hit[g])
        );
    end
    assign pm_hit  = win_hit[0];
    assign smb_hit = win_hit[1];

    pm_sci_gen #(.EVT_W(EVT_W)) u_sci (
        .sts(evt_sts), .en(evt_en), .intpin(intpin),
        .sci(sci), .tmr_arm(tmr_arm)
    );
endmodule

// File: rtl/pm_cfg_decoder_chk.sv
module pm_cfg_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        init_done,
    input logic        cfg_wr,
    input logic [5:0]  cfg_dwaddr,
    input logic [31:0] pm_base,
    input logic [31:0] sm_base,
    input logic [7:0]  pm_ctl,
    input logic [7:0]  sm_ctl,
    input logic [7:0]  intpin,
    input logic        pm_hit,
    input logic        smb_hit,
    input logic        sci,
    input logic        tmr_arm,
    input logic [15:0] evt_sts
);
    assert_pm_base_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pm_base[6:0] == 7'h01 && pm_base[31:16] == 16'h0));

    assert_sm_base_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (sm_base[3:0] == 4'h1 && sm_base[31:16] == 16'h0));

    assert_pm_hit_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_hit |-> pm_ctl[7]);

    assert_smctl_low_nibble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sm_ctl[7:4] == 4'h0);

    assert_smb_hit_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> sm_ctl[0]);

    assert_sci_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (intpin == 8'h00) |-> !sci);

    assert_tmr_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_arm |-> !evt_sts[0]);

    assert_unrelated_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cfg_wr && cfg_dwaddr != 6'h0F && cfg_dwaddr != 6'h10 &&
         cfg_dwaddr != 6'h12 && cfg_dwaddr != 6'h24 && cfg_dwaddr != 6'h34)
        |=> ($stable(pm_base) && $stable(sm_base) && $stable(pm_ctl) &&
             $stable(sm_ctl) && $stable(intpin)));

    assert_init_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind pm_cfg_decoder pm_cfg_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .cfg_wr(cfg_wr),
    .cfg_dwaddr(cfg_dwaddr), .pm_base(pm_base), .sm_base(sm_base),
    .pm_ctl(pm_ctl), .sm_ctl(sm_ctl), .intpin(intpin),
    .pm_hit(pm_hit), .smb_hit(smb_hit), .sci(sci), .tmr_arm(tmr_arm),
    .evt_sts(evt_sts)
);

// File: tb/pm_cfg_decoder_tb.sv
module pm_cfg_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [5:0]  cfg_dwaddr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        init_done;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [15:0] evt_sts = '0, evt_en = '0;
    logic        sci, tmr_arm;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;   // 250 MHz

    pm_cfg_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_dwaddr(cfg_dwaddr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .init_done(init_done), .io_addr(io_addr),
        .pm_hit(pm_hit), .smb_hit(smb_hit), .evt_sts(evt_sts),
        .evt_en(evt_en), .sci(sci), .tmr_arm(tmr_arm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dwaddr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_dwaddr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic hits(input logic [15:0] a, input logic ep, input logic es, input string req);
        io_addr = a;
        #1;
        chk(req, {30'h0, pm_hit, smb_hit}, {30'h0, ep, es});
    endtask

    // {sts, en, sci, tmr_arm}
    localparam int NV = 10;
    localparam logic [33:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0, 1'b0},
        {16'h0001, 16'h0001, 1'b1, 1'b0},
        {16'h0000, 16'h0001, 1'b0, 1'b1},
        {16'h0020, 16'h0020, 1'b1, 1'b0},
        {16'h0100, 16'h0100, 1'b1, 1'b0},
        {16'h0400, 16'h0400, 1'b1, 1'b0},
        {16'hFADE, 16'h0521, 1'b0, 1'b1},
        {16'h0521, 16'hFADE, 1'b0, 1'b0},
        {16'hFFFF, 16'hFADE, 1'b0, 1'b0},
        {16'h0500, 16'h0401, 1'b1, 1'b1}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: write during INIT_CLEAR must be dropped
        cfg_wr = 1'b1; cfg_dwaddr = 6'h10; cfg_be = 4'b0010; cfg_wdata = 32'h0000_8000;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        @(negedge clk);
        chk("R1 init_done", {31'h0, init_done}, 32'h1);
        rd(6'h12, rv); chk("R1 pm base reset", rv, 32'h1);
        rd(6'h24, rv); chk("R1 smb base reset", rv, 32'h1);
        rd(6'h10, rv); chk("R1 init write dropped", rv, 32'h0);
        rd(6'h34, rv); chk("R1 smb ctl reset", rv, 32'h0);
        hits(16'h0000, 1'b0, 1'b0, "R1 no hits");
        rd(6'h0F, rv); chk("R8 intpin reset", rv, 32'h0000_0100);

        // R7 R9 vector table
        for (int i = 0; i < NV; i++) begin
            evt_sts = VEC[i][33:18];
            evt_en  = VEC[i][17:2];
            #1;
            chk("R7 sci", {31'h0, sci}, {31'h0, VEC[i][1]});
            chk("R9 tmr_arm", {31'h0, tmr_arm}, {31'h0, VEC[i][0]});
        end

        // R2 full write
        wr(6'h12, 4'hF, 32'hDEAD_BEEF);
        rd(6'h12, rv); chk("R2 pm sanitize", rv, 32'h0000_BE81);
        // R4 single lane writes
        wr(6'h12, 4'b0100, 32'h00AA_0000);
        rd(6'h12, rv); chk("R4 lane2 wiped", rv, 32'h0000_BE81);
        wr(6'h12, 4'b0001, 32'h0000_007F);
        rd(6'h12, rv); chk("R4 lane0 merge", rv, 32'h0000_BE01);
        // R3
        wr(6'h24, 4'hF, 32'h1234_5678);
        rd(6'h24, rv); chk("R3 smb sanitize", rv, 32'h0000_5671);

        // R5 PM window
        wr(6'h12, 4'hF, 32'h0000_1000);
        hits(16'h1000, 1'b0, 1'b0, "R5 disabled");
        wr(6'h10, 4'b0010, 32'h0000_8000);
        hits(16'h1000, 1'b1, 1'b0, "R5 low edge");
        hits(16'h107F, 1'b1, 1'b0, "R5 high edge");
        hits(16'h1080, 1'b0, 1'b0, "R5 past end");
        hits(16'h0FFF, 1'b0, 1'b0, "R5 below");

        // R6 SMB window
        wr(6'h24, 4'hF, 32'h0000_2000);
        hits(16'h2000, 1'b0, 1'b0, "R6 disabled");
        wr(6'h34, 4'b0100, 32'h00FF_0000);
        rd(6'h34, rv); chk("R6 low nibble kept", rv, 32'h000F_0000);
        hits(16'h200F, 1'b0, 1'b1, "R6 inside");
        hits(16'h2010, 1'b0, 1'b0, "R6 past end");
        wr(6'h34, 4'b0100, 32'h00FE_0000);
        hits(16'h2000, 1'b0, 1'b0, "R6 bit0 clear");

        // R10 unrelated write
        wr(6'h14, 4'hF, 32'hFFFF_FFFF);
        hits(16'h1000, 1'b1, 1'b0, "R10 pm still decodes");
        rd(6'h12, rv); chk("R10 pm base kept", rv, 32'h0000_1001);
        rd(6'h14, rv); chk("R10 unmodelled reads 0", rv, 32'h0);

        // R11 rdata holds between reads
        rd(6'h24, rv);
        cfg_dwaddr = 6'h12;
        repeat (2) @(negedge clk);
        chk("R11 rdata held", cfg_rdata, 32'h0000_2001);

        // R8 intpin gating
        evt_sts = 16'h0001; evt_en = 16'h0001;
        #1; chk("R8 sci with pin", {31'h0, sci}, 32'h1);
        wr(6'h0F, 4'b0010, 32'h0);
        chk("R8 sci gated", {31'h0, sci}, 32'h0);
        chk("R9 tmr_arm status set", {31'h0, tmr_arm}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule